// File: doc/BRIEF.md
# Link Test Loopback Substate Controller

This block steers a port through the two substates of link test loopback. The first is the running test, where the port either echoes received data back to its partner or generates test data of its own. The second is the wind-down, where the port exchanges a low-frequency exit handshake under a time limit. When the controller gets an entry pulse, it latches the port's role. The role is responder when the training set that led into loopback had its loopback bit set, and originator otherwise. It keeps that role until it leaves loopback.

While the test runs, `lb_active` is high and `lb_echo` tells the datapath which behaviour to use. A responder leaves the test when the exit handshake completes. An originator leaves it when the pattern engine reports that its test is done. The controller then raises both low-frequency signalling enables and starts a cycle-count timer. A completed handshake ends loopback towards receiver detection. An expired timer ends it towards the inactive state.

In either substate, software directives on a downstream port, or a detected warm reset on an upstream port, take the port out at once. Each exit is reported by a one-cycle, one-hot `next_state` code.

Top module: `lpbk_substate_ctrl`

## Requirements
- R1: After reset and before any entry pulse, `lb_active`, `lb_echo`, both LFPS enables and `next_state` are all 0.
- R2: When the controller is idle, a high `start` enters the running substate at the next clock edge and latches `role_slave`. In that substate `lb_active` is 1 and `lb_echo` equals the latched role (1 means echo received data). Later changes on `role_slave` have no effect until loopback ends.
- R3: A responder leaves the running substate for the exit substate on `hs_done`. An originator does so on `test_done`. The strobe that belongs to the other role is ignored.
- R4: `lfps_tx_en` and `lfps_rx_en` are 1 exactly while the controller is in the exit substate. They are 0 from the cycle after it leaves.
- R5: `hs_done` in the exit substate ends loopback with `next_state` = 3'b001, where bit 0 means receiver detection.
- R6: When no `hs_done` arrives, the exit substate lasts exactly EXIT_CYCLES cycles and then ends with `next_state` = 3'b010, where bit 1 means inactive. If `hs_done` arrives in the last of those cycles, the result is 3'b001.
- R7: On a downstream port (`is_downstream` = 1), in either substate, `dir_warm` ends loopback with 3'b001 and `dir_disable` ends it with 3'b100, where bit 2 means disabled. When both are high, the warm reset wins. These directives override the handshake, the test strobe and the timer.
- R8: On an upstream port, `warm_det` ends loopback from either substate with 3'b001, and `dir_disable` and `dir_warm` are ignored. A downstream port ignores `warm_det`.
- R9: `next_state` has at most one bit set. It is non-zero for exactly one cycle per exit, and the controller is idle (`lb_active` = 0) in that cycle.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Entry pulse into loopback |
| role_slave | input | 1 | Loopback bit seen in the entry training set (1 = responder) |
| hs_done | input | 1 | Exit handshake completed strobe |
| test_done | input | 1 | Originator test complete strobe |
| is_downstream | input | 1 | Port faces downstream |
| dir_disable | input | 1 | Directive to go disabled (downstream only) |
| dir_warm | input | 1 | Directive to issue warm reset (downstream only) |
| warm_det | input | 1 | Warm reset detected (upstream only) |
| lfps_tx_en | output | 1 | Low-frequency signalling transmitter enable |
| lfps_rx_en | output | 1 | Low-frequency signalling receiver enable |
| lb_active | output | 1 | Running substate active |
| lb_echo | output | 1 | 1 = echo received data, 0 = generate test data |
| next_state | output | 3 | One-hot exit code: bit0 receiver detect, bit1 inactive, bit2 disabled |

## Verification
A wrong substate shows up at the ports one cycle after the edge that caused it. Wrongly raised or missing LFPS enables, or `lb_active` staying high after a strobe that should have ended the test, are visible at once. A role latched wrongly inverts `lb_echo` in the first cycle of the test and also changes which strobe moves the port on. An off-by-one in the timer shifts the inactive code by one cycle, so the bench counts the enable-high cycles exactly. A wrong priority shows up as the wrong one-hot bit in the single exit pulse.

// File: rtl/lpbk_pkg.sv
// Package: shared state type and exit-code bit positions for the loopback
// substate controller. Assumes one-hot exit codes of NS_W bits.
package lpbk_pkg;
    typedef enum logic [1:0] {
        LB_IDLE   = 2'd0,
        LB_ACTIVE = 2'd1,
        LB_EXIT   = 2'd2
    } lb_state_e;

    localparam int NS_W     = 3;
    localparam int NS_RXDET = 0;
    localparam int NS_INACT = 1;
    localparam int NS_DISAB = 2;
endpackage

// File: rtl/lpbk_exit_timer.sv
// Exit-substate timer: counts cycles while run is high and flags the last
// allowed cycle. Assumes run stays high for the whole exit substate and
// drops for at least one cycle between exits (count restarts from zero).
module lpbk_exit_timer #(
    parameter int EXIT_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(EXIT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(EXIT_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Flag the final cycle of the window.
    always_comb begin
        expired = run && (cnt == LAST);
    end

    // Count cycles spent in the exit substate; clear outside it.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lpbk_leave_arb.sv
// Leave arbiter: decides, per cycle, whether loopback ends (and towards which
// state) or moves from the running substate to the exit substate.
// Priority: warm reset directive, disable directive, detected warm reset,
// handshake success, timeout, then the role's own progress strobe.
module lpbk_leave_arb
    import lpbk_pkg::*;
(
    input  logic            in_active,
    input  logic            in_exit,
    input  logic            is_slave,
    input  logic            hs_done,
    input  logic            test_done,
    input  logic            timeout,
    input  logic            is_downstream,
    input  logic            dir_disable,
    input  logic            dir_warm,
    input  logic            warm_det,
    output logic            go_exit,
    output logic            leave,
    output logic [NS_W-1:0] leave_code
);
    logic progress;

    // Select the progress strobe that belongs to the latched role.
    always_comb begin
        progress = is_slave ? hs_done : test_done;
    end

    // Resolve the exit request by fixed priority.
    always_comb begin
        leave_code = '0;
        go_exit    = 1'b0;
        if (in_active || in_exit) begin
            if (is_downstream && dir_warm) begin
                leave_code[NS_RXDET] = 1'b1;
            end else if (is_downstream && dir_disable) begin
                leave_code[NS_DISAB] = 1'b1;
            end else if (!is_downstream && warm_det) begin
                leave_code[NS_RXDET] = 1'b1;
            end else if (in_exit && hs_done) begin
                leave_code[NS_RXDET] = 1'b1;
            end else if (in_exit && timeout) begin
                leave_code[NS_INACT] = 1'b1;
            end else if (in_active && progress) begin
                go_exit = 1'b1;
            end
        end
        leave = |leave_code;
    end
endmodule

// File: rtl/lpbk_fsm.sv
// Substate register: holds idle/running/exit, the latched role and the
// registered one-cycle exit code. Assumes the arbiter never raises go_exit
// and leave together.
module lpbk_fsm
    import lpbk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            role_slave,
    input  logic            go_exit,
    input  logic            leave,
    input  logic [NS_W-1:0] leave_code,
    output lb_state_e       state,
    output logic            is_slave,
    output logic [NS_W-1:0] exit_code
);
    // Advance the substate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LB_IDLE;
        end else begin
            unique case (state)
                LB_IDLE:   if (start) state <= LB_ACTIVE;
                LB_ACTIVE: if (leave) state <= LB_IDLE;
                           else if (go_exit) state <= LB_EXIT;
                LB_EXIT:   if (leave) state <= LB_IDLE;
                default:   state <= LB_IDLE;
            endcase
        end
    end

    // Latch the role once at entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_slave <= 1'b0;
        end else if (state == LB_IDLE && start) begin
            is_slave <= role_slave;
        end
    end

    // Register the exit code as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exit_code <= '0;
        end else begin
            exit_code <= leave ? leave_code : '0;
        end
    end
endmodule

// File: rtl/lpbk_substate_ctrl.sv
// Top of the loopback substate controller. Ties the timer, the leave arbiter
// and the substate register together and decodes the port-level enables.
// Assumes all strobes are synchronous to clk.
module lpbk_substate_ctrl
    import lpbk_pkg::*;
#(
    parameter int EXIT_CYCLES = 250000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            role_slave,
    input  logic            hs_done,
    input  logic            test_done,
    input  logic            is_downstream,
    input  logic            dir_disable,
    input  logic            dir_warm,
    input  logic            warm_det,
    output logic            lfps_tx_en,
    output logic            lfps_rx_en,
    output logic            lb_active,
    output logic            lb_echo,
    output logic [NS_W-1:0] next_state
);
    lb_state_e       state;
    logic            is_slave;
    logic            timeout;
    logic            go_exit;
    logic            leave;
    logic [NS_W-1:0] leave_code;
    logic            in_active;
    logic            in_exit;

    // Decode substate flags.
    always_comb begin
        in_active = (state == LB_ACTIVE);
        in_exit   = (state == LB_EXIT);
    end

    lpbk_exit_timer #(.EXIT_CYCLES(EXIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_exit),
        .expired (timeout)
    );

    lpbk_leave_arb u_arb (
        .in_active     (in_active),
        .in_exit       (in_exit),
        .is_slave      (is_slave),
        .hs_done       (hs_done),
        .test_done     (test_done),
        .timeout       (timeout),
        .is_downstream (is_downstream),
        .dir_disable   (dir_disable),
        .dir_warm      (dir_warm),
        .warm_det      (warm_det),
        .go_exit       (go_exit),
        .leave         (leave),
        .leave_code    (leave_code)
    );

    lpbk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .role_slave (role_slave),
        .go_exit    (go_exit),
        .leave      (leave),
        .leave_code (leave_code),
        .state      (state),
        .is_slave   (is_slave),
        .exit_code  (next_state)
    );

    // Drive port-level enables from the registered substate.
    always_comb begin
        lfps_tx_en = in_exit;
        lfps_rx_en = in_exit;
        lb_active  = in_active;
        lb_echo    = in_active && is_slave;
    end
endmodule

// File: rtl/lpbk_substate_chk.sv
// Checker for the loopback substate controller, observing ports only.
// The timeout window is tracked with a local counter.
module lpbk_substate_chk #(
    parameter int EXIT_CYCLES = 250000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_done,
    input logic       test_done,
    input logic       is_downstream,
    input logic       dir_disable,
    input logic       dir_warm,
    input logic       warm_det,
    input logic       lfps_tx_en,
    input logic       lfps_rx_en,
    input logic       lb_active,
    input logic       lb_echo,
    input logic [2:0] next_state
);
    int unsigned exit_len;

    // Count consecutive cycles with the transmitter enable high.
    always_ff @(posedge clk) begin
        if (!rst_n || !lfps_tx_en) exit_len <= 0;
        else exit_len <= exit_len + 1;
    end

    assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(next_state));

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (next_state != 3'b000) |=> (next_state == 3'b000));

    assert_idle_on_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (next_state != 3'b000) |-> !lb_active && !lfps_tx_en);

    assert_lfps_off_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lb_active |-> !lfps_tx_en && !lfps_rx_en);

    assert_role_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lb_active |=> (!lb_active || $stable(lb_echo)));

    assert_hs_success_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lfps_tx_en && hs_done && !(is_downstream && (dir_disable || dir_warm))
         && !(!is_downstream && warm_det)) |=> (next_state == 3'b001));

    assert_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lfps_tx_en |-> (exit_len < EXIT_CYCLES));

    assert_upstream_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_active && !is_downstream && !warm_det && !hs_done && !test_done)
        |=> lb_active);

    assert_dn_warm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((lb_active || lfps_tx_en) && is_downstream && dir_warm)
        |=> (next_state == 3'b001));
endmodule

bind lpbk_substate_ctrl lpbk_substate_chk #(.EXIT_CYCLES(EXIT_CYCLES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hs_done       (hs_done),
    .test_done     (test_done),
    .is_downstream (is_downstream),
    .dir_disable   (dir_disable),
    .dir_warm      (dir_warm),
    .warm_det      (warm_det),
    .lfps_tx_en    (lfps_tx_en),
    .lfps_rx_en    (lfps_rx_en),
    .lb_active     (lb_active),
    .lb_echo       (lb_echo),
    .next_state    (next_state)
);

// File: tb/sim_lpbk_substate_ctrl.sv
module sim_lpbk_substate_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int EXIT_CYC   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, role_slave = 0, hs_done = 0, test_done = 0;
    logic is_downstream = 1, dir_disable = 0, dir_warm = 0, warm_det = 0;
    logic lfps_tx_en, lfps_rx_en, lb_active, lb_echo;
    logic [2:0] next_state;

    int n_chk = 0;
    int n_fail = 0;
    logic [2:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lpbk_substate_ctrl #(.EXIT_CYCLES(EXIT_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .role_slave(role_slave),
        .hs_done(hs_done), .test_done(test_done), .is_downstream(is_downstream),
        .dir_disable(dir_disable), .dir_warm(dir_warm), .warm_det(warm_det),
        .lfps_tx_en(lfps_tx_en), .lfps_rx_en(lfps_rx_en), .lb_active(lb_active),
        .lb_echo(lb_echo), .next_state(next_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Driver helpers: a one-cycle strobe on a chosen input.
    task automatic pulse_start(input logic slave);
        start = 1; role_slave = slave; tick(); start = 0;
    endtask

    // Monitor: pop and compare every exit code the design produces.
    always @(negedge clk) begin
        if (rst_n && next_state != 3'b000) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R9 unexpected exit actual=%0d expected=0", next_state);
            end else begin
                chk("R9 exit code", int'(next_state), int'(exp_q.pop_front()));
                chk("R9 idle in exit cycle", int'(lb_active), 0);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 lb_active", int'(lb_active), 0);
        chk("R1 lfps_tx_en", int'(lfps_tx_en), 0);
        chk("R1 next_state", int'(next_state), 0);

        // Responder path, downstream.
        pulse_start(1'b1);
        chk("R2 lb_active", int'(lb_active), 1);
        chk("R2 lb_echo responder", int'(lb_echo), 1);
        role_slave = 0; test_done = 1; tick(); test_done = 0;
        chk("R3 test_done ignored by responder", int'(lb_active), 1);
        chk("R2 role held", int'(lb_echo), 1);
        hs_done = 1; tick(); hs_done = 0;
        chk("R4 tx enable in exit", int'(lfps_tx_en), 1);
        chk("R4 rx enable in exit", int'(lfps_rx_en), 1);
        exp_q.push_back(3'b001);
        hs_done = 1; tick(); hs_done = 0;   // R5 handshake success
        chk("R4 tx cleared after exit", int'(lfps_tx_en), 0);
        tick();
        chk("R5 idle after exit", int'(lb_active), 0);

        // Originator path with timeout.
        pulse_start(1'b0);
        chk("R2 lb_echo originator", int'(lb_echo), 0);
        hs_done = 1; tick(); hs_done = 0;
        chk("R3 hs_done ignored by originator", int'(lb_active), 1);
        exp_q.push_back(3'b010);
        test_done = 1; tick(); test_done = 0;
        n = 0;
        while (lfps_tx_en && n < 1000) begin n++; tick(); end
        chk("R6 exit window length", n, EXIT_CYC);
        chk("R4 rx cleared after timeout", int'(lfps_rx_en), 0);
        tick();

        // R6 handshake in the last window cycle wins.
        pulse_start(1'b0);
        test_done = 1; tick(); test_done = 0;
        repeat (EXIT_CYC - 1) tick();
        chk("R6 still in exit at last cycle", int'(lfps_tx_en), 1);
        exp_q.push_back(3'b001);
        hs_done = 1; tick(); hs_done = 0;
        tick();

        // R7 downstream disable directive while running.
        pulse_start(1'b1);
        exp_q.push_back(3'b100);
        dir_disable = 1; tick(); dir_disable = 0;
        tick();

        // R8 downstream ignores warm_det; R7 warm directive in exit.
        pulse_start(1'b0);
        test_done = 1; tick(); test_done = 0;
        warm_det = 1; tick(); warm_det = 0;
        chk("R8 downstream ignores warm_det", int'(lfps_tx_en), 1);
        exp_q.push_back(3'b001);
        dir_warm = 1; tick(); dir_warm = 0;
        tick();

        // R7 priority: warm over disable.
        pulse_start(1'b1);
        exp_q.push_back(3'b001);
        dir_warm = 1; dir_disable = 1; tick(); dir_warm = 0; dir_disable = 0;
        tick();

        // R8 upstream: directives ignored, warm_det honoured.
        is_downstream = 0;
        pulse_start(1'b1);
        dir_disable = 1; dir_warm = 1; tick(); dir_disable = 0; dir_warm = 0;
        chk("R8 upstream ignores directives", int'(lb_active), 1);
        exp_q.push_back(3'b001);
        warm_det = 1; tick(); warm_det = 0;
        repeat (3) tick();

        chk("R9 all exits seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule